// File: doc/BRIEF.md
# DMA Channel Address Programming Unit

This block holds the current address and current byte count for a small set of DMA channels. A host loads and reads the 16-bit registers one byte at a time through an 8-bit port. A single shared byte-pointer flip-flop picks the byte, and a clear strobe puts it in a known state. When a transfer is requested on a channel, the block translates that channel's current address into a bus address, advances the address and decrements the count.

Bit 15 of a channel address chooses the target. When it is clear, the lower 15 bits form an external memory address on a 20-bit bus whose top five lines stay low. When it is set, bits 14:10 name an internal packet and bits 9:0 give an offset inside that packet, presented on an 11-bit buffer pointer whose top bit stays low. A terminal-count flag ends a channel's run when its count wraps past zero. It also ends the run when the per-run transfer limit is reached: 1024 transfers normally, or 1016 when the 8-byte header skip is selected.

Top module: `dma_addr_prog`

## Requirements
- R1: After reset the byte pointer is 0. Each host read or write of an address or count register toggles it. A write lands in the low byte when the pointer is 0 and in the high byte when it is 1.
- R2: A pulse on `clr_ptr_i` forces the byte pointer to 0, so the next access uses the low byte.
- R3: `host_rdata_o` combinationally returns the byte of the selected register's current value that the pointer chooses. `host_reg_i[0]` selects the register (0 = address, 1 = count) and the upper bits select the channel.
- R4: A transfer on an address with bit 15 = 0 drives `ext_addr_o = {5'b0, addr[14:0]}`, `target_int_o = 0`, `pkt_num_o = 0` and `buf_ptr_o = 0`, with `xfer_vld_o` high, one cycle after the request.
- R5: A transfer on an address with bit 15 = 1 drives `target_int_o = 1`, `pkt_num_o = addr[14:10]`, `buf_ptr_o = {1'b0, addr[9:0]}` and `ext_addr_o = 0`, one cycle after the request.
- R6: Each accepted transfer decrements the current count by one. On an external address it increments bits 14:0, wrapping within 15 bits, and bit 15 stays 0.
- R7: On an internal address a transfer increments only the 10-bit offset, which wraps from 0x3FF to 0. The packet number and bit 15 never change.
- R8: A count programmed to N allows N+1 transfers; the last of them sets that channel's `tc_o` bit. While the bit is set, requests on that channel produce no `xfer_vld_o` and leave its address and count unchanged. Writing either byte of the channel's count clears the bit.
- R9: Regardless of the count, `tc_o` is set on the 1024th transfer since the last count write when `hdr_skip_i = 0`, and on the 1016th when `hdr_skip_i = 1`.
- R10: A transfer request on a channel that receives a host write in the same cycle is ignored: no `xfer_vld_o`, and the address does not advance.
- R11: Channels are independent. A terminal count or a transfer on one channel does not alter another channel's address, count or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host register write strobe |
| host_rd_i | input | 1 | Host register read strobe |
| host_reg_i | input | CH_W+1 | Register select: bit 0 count/address, upper bits channel |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte |
| clr_ptr_i | input | 1 | Clear byte-pointer strobe |
| hdr_skip_i | input | 1 | Select 1016-transfer run limit |
| xfer_req_i | input | 1 | Transfer request strobe |
| xfer_ch_i | input | CH_W | Channel of the request |
| xfer_vld_o | output | 1 | Address outputs hold a new transfer |
| target_int_o | output | 1 | 1 = internal buffer, 0 = external memory |
| ext_addr_o | output | 20 | External memory address |
| pkt_num_o | output | 5 | Internal packet number |
| buf_ptr_o | output | 11 | Internal buffer offset pointer |
| tc_o | output | NUM_CH | Terminal count flag per channel |

## Verification
Read data is combinational, so the bench samples `host_rdata_o` a moment after raising the read strobe and before the next edge. The pointer and register updates from a write show up in the access that follows. Transfer outputs and `tc_o` are registered, so they become valid on the rising edge after the request cycle. Every stimulus is applied on a falling edge and its result is checked on the next falling edge. For the run-limit cases the bench counts transfers itself and checks `tc_o` after the transfer just before the limit and after the one at the limit.

// File: rtl/dma_ap_pkg.sv
package dma_ap_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PKT_W  = 5;
  localparam int unsigned OFS_W  = 10;
  localparam int unsigned EXT_W  = 20;
  localparam int unsigned LOC_W  = PKT_W + OFS_W;

  typedef struct packed {
    logic             is_int;
    logic [PKT_W-1:0] pkt;
    logic [OFS_W-1:0] ofs;
  } chan_addr_t;

  // internal: offset wraps inside packet; external: 15-bit wrap, bit 15 kept
  function automatic chan_addr_t next_addr(chan_addr_t a);
    chan_addr_t n;
    n = a;
    if (a.is_int) n.ofs = a.ofs + 1'b1;
    else          {n.pkt, n.ofs} = {a.pkt, a.ofs} + 1'b1;
    return n;
  endfunction
endpackage

// File: rtl/dma_ap_byte_ptr.sv
module dma_ap_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic access_i,
  output logic hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_o <= 1'b0;
    else if (clr_i)    hi_o <= 1'b0;
    else if (access_i) hi_o <= ~hi_o;
  end
endmodule

// File: rtl/dma_ap_chan.sv
module dma_ap_chan
  import dma_ap_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_addr_i,
  input  logic              wr_cnt_i,
  input  logic              hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              step_i,
  input  logic [IDX_W-1:0]  last_idx_i,
  output chan_addr_t        addr_o,
  output logic [REG_W-1:0]  cnt_o,
  output logic              tc_o
);
  logic [REG_W-1:0] addr_q;
  logic [REG_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             tc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (wr_addr_i) begin
      if (hi_i) addr_q[REG_W-1:BYTE_W] <= wdata_i;
      else      addr_q[BYTE_W-1:0]     <= wdata_i;
    end else if (step_i) begin
      addr_q <= next_addr(addr_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
      tc_q  <= 1'b0;
    end else if (wr_cnt_i) begin
      if (hi_i) cnt_q[REG_W-1:BYTE_W] <= wdata_i;
      else      cnt_q[BYTE_W-1:0]     <= wdata_i;
      idx_q <= '0;
      tc_q  <= 1'b0;
    end else if (step_i) begin
      cnt_q <= cnt_q - 1'b1;
      idx_q <= idx_q + 1'b1;
      tc_q  <= (cnt_q == '0) || (idx_q == last_idx_i);
    end
  end

  assign addr_o = chan_addr_t'(addr_q);
  assign cnt_o  = cnt_q;
  assign tc_o   = tc_q;
endmodule

// File: rtl/dma_ap_map.sv
module dma_ap_map
  import dma_ap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  chan_addr_t       addr_i,
  output logic             vld_o,
  output logic             target_int_o,
  output logic [EXT_W-1:0] ext_addr_o,
  output logic [PKT_W-1:0] pkt_num_o,
  output logic [OFS_W:0]   buf_ptr_o
);
  logic [EXT_W-1:0] ext_d;
  logic [PKT_W-1:0] pkt_d;
  logic [OFS_W:0]   ptr_d;

  always_comb begin
    ext_d = '0;
    pkt_d = '0;
    ptr_d = '0;
    if (addr_i.is_int) begin
      pkt_d = addr_i.pkt;
      ptr_d = {1'b0, addr_i.ofs};
    end else begin
      ext_d = {{(EXT_W-LOC_W){1'b0}}, addr_i.pkt, addr_i.ofs};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o        <= 1'b0;
      target_int_o <= 1'b0;
      ext_addr_o   <= '0;
      pkt_num_o    <= '0;
      buf_ptr_o    <= '0;
    end else begin
      vld_o <= fire_i;
      if (fire_i) begin
        target_int_o <= addr_i.is_int;
        ext_addr_o   <= ext_d;
        pkt_num_o    <= pkt_d;
        buf_ptr_o    <= ptr_d;
      end
    end
  end
endmodule

// File: rtl/dma_addr_prog.sv
module dma_addr_prog
  import dma_ap_pkg::*;
#(
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned XFER_CAP  = 1024,
  parameter int unsigned HDR_BYTES = 8,
  localparam int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [CH_W:0]     host_reg_i,
  input  logic [7:0]        host_wdata_i,
  output logic [7:0]        host_rdata_o,
  input  logic              clr_ptr_i,
  input  logic              hdr_skip_i,
  input  logic              xfer_req_i,
  input  logic [CH_W-1:0]   xfer_ch_i,
  output logic              xfer_vld_o,
  output logic              target_int_o,
  output logic [19:0]       ext_addr_o,
  output logic [4:0]        pkt_num_o,
  output logic [10:0]       buf_ptr_o,
  output logic [NUM_CH-1:0] tc_o
);
  localparam int unsigned IDX_W = $clog2(XFER_CAP);
  localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(XFER_CAP - 1);
  localparam logic [IDX_W-1:0] LAST_SKIP = IDX_W'(XFER_CAP - HDR_BYTES - 1);

  logic             byte_hi;
  logic             sel_cnt;
  logic [CH_W-1:0]  sel_ch;
  logic [IDX_W-1:0] last_idx;
  chan_addr_t       ch_addr [NUM_CH];
  logic [REG_W-1:0] ch_cnt  [NUM_CH];
  logic [NUM_CH-1:0] step;
  logic [REG_W-1:0] rd_word;

  assign sel_cnt  = host_reg_i[0];
  assign sel_ch   = host_reg_i[CH_W:1];
  assign last_idx = hdr_skip_i ? LAST_SKIP : LAST_FULL;

  dma_ap_byte_ptr u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_ptr_i),
    .access_i (host_wr_i | host_rd_i),
    .hi_o     (byte_hi)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_here;
    assign wr_here = host_wr_i && (sel_ch == CH_W'(c));
    assign step[c] = xfer_req_i && (xfer_ch_i == CH_W'(c)) && !tc_o[c] && !wr_here;

    dma_ap_chan #(.IDX_W(IDX_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_addr_i  (wr_here && !sel_cnt),
      .wr_cnt_i   (wr_here && sel_cnt),
      .hi_i       (byte_hi),
      .wdata_i    (host_wdata_i),
      .step_i     (step[c]),
      .last_idx_i (last_idx),
      .addr_o     (ch_addr[c]),
      .cnt_o      (ch_cnt[c]),
      .tc_o       (tc_o[c])
    );
  end

  assign rd_word      = sel_cnt ? ch_cnt[sel_ch] : REG_W'(ch_addr[sel_ch]);
  assign host_rdata_o = byte_hi ? rd_word[REG_W-1:BYTE_W] : rd_word[BYTE_W-1:0];

  dma_ap_map u_map (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (|step),
    .addr_i       (ch_addr[xfer_ch_i]),
    .vld_o        (xfer_vld_o),
    .target_int_o (target_int_o),
    .ext_addr_o   (ext_addr_o),
    .pkt_num_o    (pkt_num_o),
    .buf_ptr_o    (buf_ptr_o)
  );
endmodule

// File: rtl/dma_addr_prog_chk.sv
module dma_addr_prog_chk #(
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_wr_i,
  input logic              host_rd_i,
  input logic [CH_W:0]     host_reg_i,
  input logic              clr_ptr_i,
  input logic              byte_hi,
  input logic              xfer_req_i,
  input logic [CH_W-1:0]   xfer_ch_i,
  input logic              xfer_vld_o,
  input logic              target_int_o,
  input logic [19:0]       ext_addr_o,
  input logic [10:0]       buf_ptr_o,
  input logic [NUM_CH-1:0] tc_o
);
  p_ptr_toggle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i || host_rd_i) && !clr_ptr_i |=> byte_hi != $past(byte_hi));

  p_ptr_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ptr_i |=> !byte_hi);

  p_ext_top_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_vld_o && !target_int_o |-> ext_addr_o[19:15] == 5'd0);

  p_vld_after_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_vld_o |-> $past(xfer_req_i));

  p_int_ptr_b10_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_vld_o && target_int_o |-> !buf_ptr_o[10] && ext_addr_o == 20'd0);

  p_tc_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_i && tc_o[xfer_ch_i] |=> !xfer_vld_o);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_tc
    p_tc_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_o[c] && !(host_wr_i && host_reg_i == {CH_W'(c), 1'b1}) |=> tc_o[c]);
  end
endmodule

bind dma_addr_prog dma_addr_prog_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_wr_i    (host_wr_i),
  .host_rd_i    (host_rd_i),
  .host_reg_i   (host_reg_i),
  .clr_ptr_i    (clr_ptr_i),
  .byte_hi      (byte_hi),
  .xfer_req_i   (xfer_req_i),
  .xfer_ch_i    (xfer_ch_i),
  .xfer_vld_o   (xfer_vld_o),
  .target_int_o (target_int_o),
  .ext_addr_o   (ext_addr_o),
  .buf_ptr_o    (buf_ptr_o),
  .tc_o         (tc_o)
);

// File: tb/dma_addr_prog_test.sv
module dma_addr_prog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, clr = 1'b0, skip = 1'b0, req = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [7:0]  wdata = '0;
  logic [0:0]  ch = '0;
  logic [7:0]  rdata;
  logic        vld, tint;
  logic [19:0] ext;
  logic [4:0]  pkt;
  logic [10:0] bptr;
  logic [1:0]  tc;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dma_addr_prog uut (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(wr), .host_rd_i(rd),
    .host_reg_i(reg_sel), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .clr_ptr_i(clr), .hdr_skip_i(skip), .xfer_req_i(req), .xfer_ch_i(ch),
    .xfer_vld_o(vld), .target_int_o(tint), .ext_addr_o(ext),
    .pkt_num_o(pkt), .buf_ptr_o(bptr), .tc_o(tc)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_up();
    end
  end

  // reg encoding: {channel, is_count}
  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic wr_byte(logic [1:0] r, logic [7:0] d);
    @(negedge clk); wr = 1'b1; reg_sel = r; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_byte(logic [1:0] r, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; reg_sel = r;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wr_word(logic [1:0] r, logic [15:0] d);
    pulse_clr();
    wr_byte(r, d[7:0]);
    wr_byte(r, d[15:8]);
  endtask

  task automatic rd_word(logic [1:0] r, output logic [15:0] d);
    logic [7:0] lo, hi;
    pulse_clr();
    rd_byte(r, lo);
    rd_byte(r, hi);
    d = {hi, lo};
  endtask

  task automatic xfer(logic c);
    @(negedge clk); req = 1'b1; ch = c;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] w;
    check("R1 reset tc", 32'(tc), 0);
    check("R1 reset vld", 32'(vld), 0);
    rd_word(2'b00, w);
    check("R3 reset addr", 32'(w), 0);
  endtask

  task automatic t_ptr();
    logic [15:0] w;
    wr_word(2'b00, 16'h1234);
    rd_word(2'b00, w);
    check("R1 R3 byte order", 32'(w), 32'h1234);
    pulse_clr();
    rd_byte(2'b00, w[7:0]);     // read toggles pointer
    wr_byte(2'b00, 8'hAB);      // lands in high byte
    rd_word(2'b00, w);
    check("R1 read toggles", 32'(w), 32'hAB34);
  endtask

  task automatic t_clr();
    logic [15:0] w;
    wr_word(2'b01, 16'h0000);
    pulse_clr();
    wr_byte(2'b01, 8'h11);      // pointer now 1
    pulse_clr();
    wr_byte(2'b01, 8'h22);      // back to low byte
    rd_word(2'b01, w);
    check("R2 clear pointer", 32'(w), 32'h0022);
  endtask

  task automatic t_ext();
    logic [15:0] w;
    wr_word(2'b00, 16'h1234);
    wr_word(2'b01, 16'd10);
    xfer(1'b0);
    check("R4 vld", 32'(vld), 1);
    check("R4 target", 32'(tint), 0);
    check("R4 ext addr", 32'(ext), 32'h01234);
    check("R4 buf ptr", 32'(bptr), 0);
    xfer(1'b0);
    check("R6 ext advance", 32'(ext), 32'h01235);
    rd_word(2'b00, w);
    check("R6 addr after 2", 32'(w), 32'h1236);
    rd_word(2'b01, w);
    check("R6 count after 2", 32'(w), 32'd8);
    wr_word(2'b00, 16'h7FFF);
    xfer(1'b0);
    check("R6 ext top", 32'(ext), 32'h07FFF);
    xfer(1'b0);
    check("R6 ext wrap", 32'(ext), 32'h00000);
    check("R6 wrap stays ext", 32'(tint), 0);
  endtask

  task automatic t_int();
    logic [15:0] w;
    wr_word(2'b10, 16'h97FE);   // internal, pkt 5, ofs 0x3FE
    wr_word(2'b11, 16'd20);
    xfer(1'b1);
    check("R5 target", 32'(tint), 1);
    check("R5 pkt", 32'(pkt), 5);
    check("R5 ptr", 32'(bptr), 32'h3FE);
    check("R5 ext zero", 32'(ext), 0);
    xfer(1'b1);
    check("R7 ptr 3FF", 32'(bptr), 32'h3FF);
    xfer(1'b1);
    check("R7 ptr wrap", 32'(bptr), 0);
    check("R7 pkt kept", 32'(pkt), 5);
    rd_word(2'b10, w);
    check("R7 addr reg", 32'(w), 32'h9401);
  endtask

  task automatic t_tc();
    logic [15:0] w;
    wr_word(2'b00, 16'h0100);
    wr_word(2'b01, 16'd3);
    for (int i = 0; i < 3; i++) xfer(1'b0);
    check("R8 no tc yet", 32'(tc[0]), 0);
    xfer(1'b0);
    check("R8 tc set", 32'(tc[0]), 1);
    check("R11 other tc", 32'(tc[1]), 0);
    xfer(1'b0);
    check("R8 blocked vld", 32'(vld), 0);
    rd_word(2'b00, w);
    check("R8 addr held", 32'(w), 32'h0104);
    rd_word(2'b01, w);
    check("R8 count wrapped", 32'(w), 32'hFFFF);
    xfer(1'b1);
    check("R11 ch1 runs", 32'(vld), 1);
    check("R11 ch1 ptr", 32'(bptr), 32'h001);
    wr_word(2'b01, 16'd1);
    check("R8 rearm tc", 32'(tc[0]), 0);
    xfer(1'b0);
    check("R8 rearm vld", 32'(vld), 1);
    check("R8 rearm addr", 32'(ext), 32'h00104);
  endtask

  task automatic t_cap(logic s, int lim, string tag);
    skip = s;
    wr_word(2'b00, 16'h0000);
    wr_word(2'b01, 16'hFFFF);
    for (int i = 0; i < lim - 1; i++) xfer(1'b0);
    check({tag, " before limit"}, 32'(tc[0]), 0);
    xfer(1'b0);
    check({tag, " at limit"}, 32'(tc[0]), 1);
    skip = 1'b0;
  endtask

  task automatic t_collide();
    logic [15:0] w;
    wr_word(2'b00, 16'h0200);
    wr_word(2'b01, 16'd50);
    pulse_clr();
    @(negedge clk); wr = 1'b1; reg_sel = 2'b01; wdata = 8'd40; req = 1'b1; ch = 1'b0;
    @(negedge clk); wr = 1'b0; req = 1'b0;
    check("R10 no vld", 32'(vld), 0);
    rd_word(2'b00, w);
    check("R10 addr held", 32'(w), 32'h0200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ptr();
    t_clr();
    t_ext();
    t_int();
    t_tc();
    t_cap(1'b0, 1024, "R9 full");
    t_cap(1'b1, 1016, "R9 skip");
    t_collide();
    finish_up();
  end
endmodule